// File: doc/BRIEF.md
# Asynchronous Static Memory Controller

This block connects an on-chip master to an external asynchronous static memory of 131072 words of 32 bits. The memory module has four 8-bit dies, and each die has its own active-low select and its own active-low write strobe. The master places one transfer at a time on a request/acknowledge port. A transfer has a 17-bit word address, a read/write flag, 32-bit write data and a 4-bit byte mask. The controller then runs the memory pins through a read or write cycle. Every phase of that cycle is timed by cycle counts that are worked out at elaboration from nanosecond timing parameters and the clock period.

A write selects and strobes only the dies whose mask bit is set. The other dies, and their stored bytes, are left untouched. A read selects all four dies and drops the shared output-enable. It holds the access for the required number of cycles, captures the word into a register and acknowledges. The controller never drives the data bus while the memory may still be driving it. It also stops driving one cycle after the write strobe ends.

Top module: `sram_ctl`

## Requirements
- R1: In reset and directly after it, all die selects, all write strobes and the output-enable are high, the bus driver enable is low and the acknowledge is low.
- R2: A full-mask write followed by a read of the same word address returns the written word, for every address of a walking-one pattern over all 17 address bits and for address zero.
- R3: Mask bit n governs data bits [8n+7:8n]. A write drops the select and the strobe only on the dies whose mask bit is 1. Bytes whose mask bit is 0 keep their previous contents.
- R4: During a read, all four selects are low, all strobes are high and the output-enable is low. The word is captured after ACC access cycles (2 with the default timing), and the acknowledge appears ACC+1 clock edges after the accepting edge.
- R5: A write strobe is low only while the same die's select is low. It stays low for WP consecutive cycles (2 with the default timing). The address does not change while any select stays low.
- R6: When no bus turnaround is pending, a masked write is acknowledged WP+2 clock edges after the accepting edge.
- R7: The bus driver enable is high in every cycle with a write strobe low and in the one cycle after the strobes rise. In the cycle after that it is low.
- R8: After a read, the bus driver is enabled only once the output-enable has been high for more than TA complete cycles (TA = 2 with the default timing, so at least 3).
- R9: A write with an all-zero mask is acknowledged one edge after acceptance. It drops no select and no strobe, and it leaves the addressed word unchanged.
- R10: Each accepted transfer gives an acknowledge that is high for exactly one cycle. A request is only taken while the controller is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Transfer request, held until acknowledge |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte mask, bit n for bits [8n+7:8n] |
| ack | output | 1 | One-cycle completion pulse |
| rd_data | output | 32 | Captured read word |
| mem_addr | output | 17 | Memory address pins |
| mem_cs_n | output | 4 | Per-die select, active low |
| mem_we_n | output | 4 | Per-die write strobe, active low |
| mem_oe_n | output | 1 | Shared output-enable, active low |
| mem_dq_out | output | 32 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Bus driver enable |
| mem_dq_in | input | 32 | Data returned by the memory |

## Verification
Full-word writes and reads at address zero and on a walking one over every address bit show whether each address bit reaches the pins and whether the data lanes are crossed. All sixteen mask values are written over a known word and read back. This separates correct per-die selection from mask bits that are swapped or ignored, and the all-zero mask case separates a silent completion from a stray strobe. The memory model in the bench returns a garbage word until the access time has passed, and it claims the bus until the output-enable has been high long enough. Early capture and bus contention therefore show up as errors that can be seen. Cycle counts from acceptance to acknowledge tell the write, read, turnaround and empty-mask paths apart.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    localparam int SRAM_AW    = 17;
    localparam int SRAM_DW    = 32;
    localparam int SRAM_LANES = 4;
    localparam int LANE_W     = SRAM_DW / SRAM_LANES;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_WPULSE,
        ST_WREC,
        ST_RACC,
        ST_ACK
    } ctl_state_e;

    typedef struct packed {
        logic [SRAM_AW-1:0]    addr;
        logic [SRAM_DW-1:0]    wdata;
        logic [SRAM_LANES-1:0] be;
    } xfer_t;

    // whole clock cycles covering a delay, never below one
    function automatic int cycles_for(input int delay_ps, input int clk_ps);
        int c;
        c = (delay_ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctl_wait.sv
module sram_ctl_wait #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/sram_ctl_turn.sv
module sram_ctl_turn #(
    parameter int TA_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic oe_n,
    output logic ready
);
    localparam int TW = $clog2(TA_CYC + 1);

    logic [TW-1:0] high_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            high_cnt <= '0;
        end else if (!oe_n) begin
            high_cnt <= '0;
        end else if (high_cnt != TW'(TA_CYC)) begin
            high_cnt <= high_cnt + 1'b1;
        end
    end

    assign ready = (high_cnt == TW'(TA_CYC));

    AST_TURN_AFTER_OE_HIGH: assert property (@(posedge clk) disable iff (rst)
        ready |-> $past(oe_n)); // R8
endmodule

// File: rtl/sram_ctl_lanes.sv
module sram_ctl_lanes #(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_sel,
    input  logic             wr_sel,
    input  logic [LANES-1:0] be,
    output logic [LANES-1:0] cs_n,
    output logic [LANES-1:0] we_n
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign cs_n[l] = !(rd_sel || (wr_sel && be[l]));
        assign we_n[l] = !(wr_sel && be[l]);

        AST_WE_INSIDE_CS: assert property (@(posedge clk) disable iff (rst)
            !we_n[l] |-> !cs_n[l]); // R5
    end
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int CLK_PS    = 5000,
    parameter int T_WC_PS   = 10000,
    parameter int T_AW_PS   = 9000,
    parameter int T_WP_PS   = 9000,
    parameter int T_DS_PS   = 5000,
    parameter int T_RC_PS   = 10000,
    parameter int T_AA_PS   = 10000,
    parameter int T_ACS_PS  = 10000,
    parameter int T_HZOE_PS = 5500
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req,
    input  logic                  req_wr,
    input  logic [SRAM_AW-1:0]    req_addr,
    input  logic [SRAM_DW-1:0]    req_wdata,
    input  logic [SRAM_LANES-1:0] req_be,
    output logic                  ack,
    output logic [SRAM_DW-1:0]    rd_data,
    output logic [SRAM_AW-1:0]    mem_addr,
    output logic [SRAM_LANES-1:0] mem_cs_n,
    output logic [SRAM_LANES-1:0] mem_we_n,
    output logic                  mem_oe_n,
    output logic [SRAM_DW-1:0]    mem_dq_out,
    output logic                  mem_dq_oe,
    input  logic [SRAM_DW-1:0]    mem_dq_in
);
    // write strobe covers pulse width, address-to-end, data setup and cycle minus recovery
    localparam int WP_CYC = imax(imax(cycles_for(T_WP_PS, CLK_PS), cycles_for(T_AW_PS, CLK_PS)),
                                 imax(cycles_for(T_DS_PS, CLK_PS), cycles_for(T_WC_PS, CLK_PS) - 1));
    localparam int ACC_CYC = imax(imax(cycles_for(T_AA_PS, CLK_PS), cycles_for(T_ACS_PS, CLK_PS)),
                                  cycles_for(T_RC_PS, CLK_PS) - 1);
    localparam int TA_CYC = cycles_for(T_HZOE_PS, CLK_PS);
    localparam int CNT_W  = $clog2(imax(WP_CYC, ACC_CYC) + 1);

    ctl_state_e state, state_nx;
    xfer_t      xf;
    logic       wait_load, wait_done, turn_ok;
    logic [CNT_W-1:0] wait_val;

    always_comb begin
        state_nx  = state;
        wait_load = 1'b0;
        wait_val  = CNT_W'(WP_CYC - 1);
        unique case (state)
            ST_IDLE: if (req) begin
                if (!req_wr) begin
                    state_nx  = ST_RACC;
                    wait_load = 1'b1;
                    wait_val  = CNT_W'(ACC_CYC - 1);
                end else if (req_be == '0) begin
                    state_nx = ST_ACK;
                end else if (turn_ok) begin
                    state_nx  = ST_WPULSE;
                    wait_load = 1'b1;
                end else begin
                    state_nx = ST_TURN;
                end
            end
            ST_TURN: if (turn_ok) begin
                state_nx  = ST_WPULSE;
                wait_load = 1'b1;
            end
            ST_WPULSE: if (wait_done) state_nx = ST_WREC;
            ST_WREC:   state_nx = ST_ACK;
            ST_RACC:   if (wait_done) state_nx = ST_ACK;
            ST_ACK:    state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            xf      <= '0;
            rd_data <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && req) begin
                xf.addr  <= req_addr;
                xf.wdata <= req_wdata;
                xf.be    <= req_be;
            end
            if (state == ST_RACC && wait_done) begin
                rd_data <= mem_dq_in;
            end
        end
    end

    sram_ctl_wait #(.CNT_W(CNT_W)) u_wait (
        .clk      (clk),
        .rst      (rst),
        .load     (wait_load),
        .load_val (wait_val),
        .done     (wait_done)
    );

    sram_ctl_turn #(.TA_CYC(TA_CYC)) u_turn (
        .clk   (clk),
        .rst   (rst),
        .oe_n  (mem_oe_n),
        .ready (turn_ok)
    );

    sram_ctl_lanes #(.LANES(SRAM_LANES)) u_lanes (
        .clk    (clk),
        .rst    (rst),
        .rd_sel (state == ST_RACC),
        .wr_sel (state == ST_WPULSE),
        .be     (xf.be),
        .cs_n   (mem_cs_n),
        .we_n   (mem_we_n)
    );

    assign ack        = (state == ST_ACK);
    assign mem_addr   = xf.addr;
    assign mem_oe_n   = (state != ST_RACC);
    assign mem_dq_out = xf.wdata;
    assign mem_dq_oe  = (state == ST_WPULSE) || (state == ST_WREC);

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack); // R10
    AST_STROBE_WITH_DRIVE: assert property (@(posedge clk) disable iff (rst)
        !(&mem_we_n) |-> (mem_dq_oe && mem_oe_n)); // R7
    AST_BUS_RELEASE: assert property (@(posedge clk) disable iff (rst)
        ($past(mem_dq_oe) && (&mem_we_n) && $past(&mem_we_n)) |-> !mem_dq_oe); // R7
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (!(&mem_cs_n) && !(&$past(mem_cs_n))) |-> $stable(mem_addr)); // R5
    AST_READ_SHAPE: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> ((&mem_we_n) && (mem_cs_n == '0))); // R4
    AST_EMPTY_MASK_ACK: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && req && req_wr && req_be == '0) |=> (ack && (&mem_cs_n))); // R9
endmodule

// File: tb/sram_ctl_tb.sv
`timescale 1ns/1ps
module sram_ctl_tb;
    localparam int CLK_PS = 5000;

    function automatic int cyc(input int ps);
        int c;
        c = (ps + CLK_PS - 1) / CLK_PS;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int WP_E  = 2;  // ceil(9000/5000)
    localparam int ACC_E = 2;  // ceil(10000/5000)
    localparam int TA_E  = 2;  // ceil(5500/5000)

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        req_wr = 1'b0;
    logic [16:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic        ack;
    logic [31:0] rd_data;
    logic [16:0] mem_addr;
    logic [3:0]  mem_cs_n, mem_we_n;
    logic        mem_oe_n, mem_dq_oe;
    logic [31:0] mem_dq_out;
    logic [31:0] mem_dq_in = 32'hA5A5_5A5A;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    sram_ctl u_dut (
        .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .ack(ack), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    // memory model and pin monitors, all at the falling edge
    logic [31:0] mem [logic [16:0]];
    int rd_cnt = 0;
    int hz_cnt = 0;
    int we_len [4] = '{0, 0, 0, 0};
    logic prev_we_high = 1'b1;
    logic prev_dq_oe = 1'b0;
    logic prev_cs_any = 1'b0;
    logic [16:0] prev_addr = '0;
    int err_r4 = 0, err_r5 = 0, err_r7 = 0, err_r8 = 0;

    always @(negedge clk) begin
        logic [31:0] w;
        if (!rst) begin
            w = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
            for (int l = 0; l < 4; l++) begin
                if (!mem_cs_n[l] && !mem_we_n[l]) w[8*l +: 8] = mem_dq_out[8*l +: 8];
                if (!mem_we_n[l]) begin
                    we_len[l]++;
                    if (mem_cs_n[l]) err_r5++;
                end else begin
                    if (we_len[l] != 0 && we_len[l] < cyc(9000)) err_r5++;
                    we_len[l] = 0;
                end
            end
            if (!(&mem_we_n)) begin
                mem[mem_addr] = w;
                if (!mem_dq_oe || !mem_oe_n) err_r7++;
            end
            if (mem_dq_oe && (&mem_we_n) && prev_we_high && prev_dq_oe) err_r7++;
            if (mem_dq_oe && !prev_dq_oe && hz_cnt < TA_E + 1) err_r8++;
            if (!(&mem_cs_n) && prev_cs_any && mem_addr != prev_addr) err_r5++;
            if (!mem_oe_n && (!(&mem_we_n) || mem_cs_n != 4'b0000)) err_r4++;
            if (!mem_oe_n && (&mem_we_n)) rd_cnt++;
            else rd_cnt = 0;
            mem_dq_in = (rd_cnt >= cyc(10000)) ?
                        (mem.exists(mem_addr) ? mem[mem_addr] : 32'h0) : 32'hA5A5_5A5A;
            hz_cnt = mem_oe_n ? hz_cnt + 1 : 0;
            prev_we_high = &mem_we_n;
            prev_dq_oe = mem_dq_oe;
            prev_cs_any = !(&mem_cs_n);
            prev_addr = mem_addr;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic wr, input logic [16:0] a, input logic [31:0] d,
                        input logic [3:0] be, output logic [31:0] rdv, output int lat);
        @(negedge clk);
        req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d; req_be = be;
        lat = 0;
        for (int i = 0; i < 100; i++) begin
            @(posedge clk); lat++; #1;
            if (ack) break;
        end
        rdv = rd_data;
        req = 1'b0;
        @(posedge clk); #1;
        check("R10 ack one cycle", {31'b0, ack}, 32'h0);
    endtask

    function automatic logic [31:0] pat(input logic [16:0] a, input int k);
        return (32'(a) * 32'h9E37_79B1) ^ (32'(k) * 32'h0101_0101) ^ 32'h3C5A_0F96;
    endfunction

    function automatic logic [31:0] lane_mask(input logic [3:0] be);
        logic [31:0] m;
        for (int l = 0; l < 4; l++) m[8*l +: 8] = {8{be[l]}};
        return m;
    endfunction

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] rv, exp;
        int lat;
        logic [16:0] a;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1 cs_n", {28'b0, mem_cs_n}, 32'hF);
        check("R1 we_n", {28'b0, mem_we_n}, 32'hF);
        check("R1 oe_n/dq_oe/ack", {29'b0, mem_oe_n, mem_dq_oe, ack}, 32'h4);
        @(negedge clk); rst = 1'b0;
        repeat (5) @(posedge clk);
        #1;
        check("R1 after reset", {22'b0, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 32'h3FE);

        // R2 / R4 / R6 walking-one address sweep
        for (int b = -1; b < 17; b++) begin
            a = (b < 0) ? 17'h0 : (17'h1 << b);
            xfer(1'b1, a, pat(a, 0), 4'hF, rv, lat);
            check("R6 write latency", 32'(lat), 32'(WP_E + 2));
            xfer(1'b1, a + 17'd3, pat(a + 17'd3, 9), 4'hF, rv, lat);
        end
        for (int b = -1; b < 17; b++) begin
            a = (b < 0) ? 17'h0 : (17'h1 << b);
            xfer(1'b0, a, 32'h0, 4'h0, rv, lat);
            check("R2 read data", rv, pat(a, 0));
            check("R4 read latency", 32'(lat), 32'(ACC_E + 1));
        end

        // R3 / R9 all sixteen byte masks over a known word
        a = 17'h1_2345;
        for (int m = 0; m < 16; m++) begin
            xfer(1'b1, a, pat(a, 1), 4'hF, rv, lat);
            xfer(1'b1, a, pat(a, m + 2), 4'(m), rv, lat);
            if (m == 0) check("R9 empty mask latency", 32'(lat), 32'h1);
            xfer(1'b0, a, 32'h0, 4'h0, rv, lat);
            exp = (pat(a, 1) & ~lane_mask(4'(m))) | (pat(a, m + 2) & lane_mask(4'(m)));
            check(m == 0 ? "R9 word unchanged" : "R3 masked merge", rv, exp);
        end

        // R8 write directly after a read, then R2 readback
        xfer(1'b0, 17'h0, 32'h0, 4'h0, rv, lat);
        xfer(1'b1, 17'h0_0077, 32'hCAFE_F00D, 4'hF, rv, lat);
        xfer(1'b0, 17'h0_0077, 32'h0, 4'h0, rv, lat);
        check("R8 write after read data", rv, 32'hCAFE_F00D);

        repeat (3) @(posedge clk);
        check("R4 pin shape during reads", 32'(err_r4), 32'h0);
        check("R5 strobe width/select/address", 32'(err_r5), 32'h0);
        check("R7 bus drive window", 32'(err_r7), 32'h0);
        check("R8 turnaround before drive", 32'(err_r8), 32'h0);
        summary();
        $finish;
    end
endmodule